// File: doc/BRIEF.md
# Four-Core Interrupt Router

This block gathers the interrupt sources of a four-core cluster and turns them into one IRQ line and one FIQ line per core. Each core contributes four timer levels, four mailbox levels and a performance-monitor level; one graphics interrupt is shared by the whole cluster. The mailbox storage and the timers live in other blocks. This block only receives their level outputs.

Software programs it through a 32-bit register port. It sets per-core enable masks for timers and mailboxes, and an FIQ enable takes precedence over the IRQ enable of the same source. A routing register steers the graphics interrupt to exactly one core, either as IRQ or as FIQ. The performance-monitor enables are changed through a pair of write-one-to-set and write-one-to-clear locations.

Per-core pending registers show which sources are currently asserting on each line. Pending bits follow the source levels in the same cycle, with no latching. A register write takes effect after the clock edge that captures it.

Top module: `irq_router_top`

## Requirements
- R1: After reset every enable is 0 and the graphics routing register reads 0 (IRQ to core 0, FIQ mode off). Every output and every register read returns 0 while the inputs are quiet.
- R2: The timer control word of core c is at 0x040+4c, and bits [3:0] enable timer 0..3 of that core onto IRQ. An enabled, asserted timer t sets IRQ-pending bit t of core c.
- R3: Bits [7:4] of a timer control word enable timer 0..3 onto FIQ. An asserted timer with its FIQ enable set shows in FIQ-pending bit t and never in IRQ-pending, whatever the value of its IRQ enable.
- R4: The mailbox control word of core c is at 0x050+4c and has the same layout (IRQ [3:0], overriding FIQ [7:4]). Mailbox m maps to pending bit 4+m.
- R5: The routing register is at 0x00c and uses bits [1:0] for the IRQ core, [3:2] for the FIQ core and bit 4 for FIQ mode. With bit 4 clear, an asserted graphics input sets IRQ-pending bit 8 of the IRQ core only.
- R6: With routing bit 4 set, an asserted graphics input sets FIQ-pending bit 8 of the FIQ core only. It raises no IRQ anywhere.
- R7: Ones written to bits [3:0] at 0x010 set the performance-monitor enables of those cores. Ones written at 0x014 clear them. Zero bits leave an enable unchanged. Reading 0x010 returns the 4-bit enable mask.
- R8: An asserted performance-monitor input of an enabled core sets IRQ-pending bit 9 of that core. It never reaches FIQ.
- R9: IRQ-pending of core c reads at 0x060+4c and FIQ-pending at 0x070+4c. A core's IRQ output is the OR of its IRQ-pending bits, its FIQ output is the OR of its FIQ-pending bits, and both follow source levels within the same cycle.
- R10: Writes to unmapped addresses change no state, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_lvl_i | input | 16 | Timer levels, bit 4c+t is timer t of core c |
| mbx_lvl_i | input | 16 | Mailbox levels, bit 4c+m is mailbox m of core c |
| gfx_lvl_i | input | 1 | Shared graphics interrupt level |
| pmon_lvl_i | input | 4 | Performance-monitor level per core |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| core_irq_o | output | 4 | IRQ line per core |
| core_fiq_o | output | 4 | FIQ line per core |

## Verification
The assertions check on every cycle that the graphics interrupt appears on at most one core and that the performance-monitor set and clear strobes take effect on the next cycle. They also check that a quiet core raises no line and that an enabled monitor source always drives IRQ. Only the bench scenarios can show the register offsets and bit positions. This includes FIQ taking precedence over IRQ, mailbox mapping, routing to a particular core, and the unmapped-address behaviour, because these depend on the software view rather than on one relation between signals.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int NCORE   = 4;
    localparam int NGRP    = 4;               // timers or mailboxes per core
    localparam int PEND_W  = 10;
    localparam int CIDX_W  = $clog2(NCORE);
    localparam int CTL_W   = 2 * NGRP;
    localparam int BIT_MBX = NGRP;            // first mailbox pending bit
    localparam int BIT_GFX = 2 * NGRP;
    localparam int BIT_PMU = 2 * NGRP + 1;

    localparam logic [7:0] A_ROUTE = 8'h0C;
    localparam logic [7:0] A_PSET  = 8'h10;
    localparam logic [7:0] A_PCLR  = 8'h14;
    localparam logic [3:0] PG_TCTL = 4'h4;
    localparam logic [3:0] PG_MCTL = 4'h5;
    localparam logic [3:0] PG_IPND = 4'h6;
    localparam logic [3:0] PG_FPND = 4'h7;

    typedef logic [PEND_W-1:0] pend_t;
    typedef logic [CTL_W-1:0]  ctl_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    input  pend_t                    ipend [NCORE],
    input  pend_t                    fpend [NCORE],
    output ctl_t                     tctl  [NCORE],
    output ctl_t                     mctl  [NCORE],
    output logic [4:0]               route,
    output logic [NCORE-1:0]         pmu_en
);
    logic [3:0]        page;
    logic [CIDX_W-1:0] idx;
    logic              aligned;

    assign page    = cfg_addr[7:4];
    assign idx     = cfg_addr[CIDX_W+1:2];
    assign aligned = (cfg_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCORE; c++) begin
                tctl[c] <= '0;
                mctl[c] <= '0;
            end
            route  <= '0;
            pmu_en <= '0;
        end else if (cfg_we && aligned) begin
            if (cfg_addr == A_ROUTE) route <= cfg_wdata[4:0];
            if (cfg_addr == A_PSET)  pmu_en <= pmu_en | cfg_wdata[NCORE-1:0];
            if (cfg_addr == A_PCLR)  pmu_en <= pmu_en & ~cfg_wdata[NCORE-1:0];
            if (page == PG_TCTL)     tctl[idx] <= cfg_wdata[CTL_W-1:0];
            if (page == PG_MCTL)     mctl[idx] <= cfg_wdata[CTL_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (aligned) begin
            unique case (page)
                4'h0: if (cfg_addr == A_ROUTE) cfg_rdata[4:0] = route;
                4'h1: if (cfg_addr == A_PSET)  cfg_rdata[NCORE-1:0] = pmu_en;
                PG_TCTL: cfg_rdata[CTL_W-1:0]  = tctl[idx];
                PG_MCTL: cfg_rdata[CTL_W-1:0]  = mctl[idx];
                PG_IPND: cfg_rdata[PEND_W-1:0] = ipend[idx];
                PG_FPND: cfg_rdata[PEND_W-1:0] = fpend[idx];
                default: cfg_rdata = '0;
            endcase
        end
    end

    AST_PMU_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_PSET) |=> ((pmu_en & $past(cfg_wdata[NCORE-1:0])) == $past(cfg_wdata[NCORE-1:0]))); // R7
    AST_PMU_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_PCLR) |=> ((pmu_en & $past(cfg_wdata[NCORE-1:0])) == '0)); // R7
    AST_PMU_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (cfg_addr == A_PSET || cfg_addr == A_PCLR)) |=> $stable(pmu_en)); // R10
endmodule

// File: rtl/irq_core_route.sv
module irq_core_route
    import irq_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] tmr_i,
    input  logic [NGRP-1:0] mbx_i,
    input  ctl_t            tctl,
    input  ctl_t            mctl,
    input  logic            gfx_irq_hit,
    input  logic            gfx_fiq_hit,
    input  logic            pmu_i,
    input  logic            pmu_en,
    output pend_t           ipend,
    output pend_t           fpend,
    output logic            irq_o,
    output logic            fiq_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_src
        assign fpend[g]         = tmr_i[g] & tctl[NGRP+g];
        assign ipend[g]         = tmr_i[g] & tctl[g] & ~tctl[NGRP+g];
        assign fpend[BIT_MBX+g] = mbx_i[g] & mctl[NGRP+g];
        assign ipend[BIT_MBX+g] = mbx_i[g] & mctl[g] & ~mctl[NGRP+g];
    end

    assign ipend[BIT_GFX] = gfx_irq_hit;
    assign fpend[BIT_GFX] = gfx_fiq_hit;
    assign ipend[BIT_PMU] = pmu_i & pmu_en;
    assign fpend[BIT_PMU] = 1'b0;

    assign irq_o = |ipend;
    assign fiq_o = |fpend;

    AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ipend & fpend) == '0); // R3
    AST_PMU_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pmu_i && pmu_en) |-> (irq_o && !fpend[BIT_PMU])); // R8
    AST_QUIET_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_i == '0 && mbx_i == '0 && !gfx_irq_hit && !gfx_fiq_hit && !pmu_i)
        |-> (!irq_o && !fiq_o)); // R9
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irq_router_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCORE*NGRP-1:0]  tmr_lvl_i,
    input  logic [NCORE*NGRP-1:0]  mbx_lvl_i,
    input  logic                   gfx_lvl_i,
    input  logic [NCORE-1:0]       pmon_lvl_i,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    output logic [NCORE-1:0]       core_irq_o,
    output logic [NCORE-1:0]       core_fiq_o
);
    pend_t             ipend [NCORE];
    pend_t             fpend [NCORE];
    ctl_t              tctl  [NCORE];
    ctl_t              mctl  [NCORE];
    logic [4:0]        route;
    logic [NCORE-1:0]  pmu_en;
    logic [NCORE-1:0]  gfx_irq_hit;
    logic [NCORE-1:0]  gfx_fiq_hit;

    irq_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ipend     (ipend),
        .fpend     (fpend),
        .tctl      (tctl),
        .mctl      (mctl),
        .route     (route),
        .pmu_en    (pmu_en)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign gfx_irq_hit[c] = gfx_lvl_i & ~route[4] & (route[1:0] == CIDX_W'(c));
        assign gfx_fiq_hit[c] = gfx_lvl_i &  route[4] & (route[3:2] == CIDX_W'(c));

        irq_core_route u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .tmr_i       (tmr_lvl_i[c*NGRP +: NGRP]),
            .mbx_i       (mbx_lvl_i[c*NGRP +: NGRP]),
            .tctl        (tctl[c]),
            .mctl        (mctl[c]),
            .gfx_irq_hit (gfx_irq_hit[c]),
            .gfx_fiq_hit (gfx_fiq_hit[c]),
            .pmu_i       (pmon_lvl_i[c]),
            .pmu_en      (pmu_en[c]),
            .ipend       (ipend[c]),
            .fpend       (fpend[c]),
            .irq_o       (core_irq_o[c]),
            .fiq_o       (core_fiq_o[c])
        );
    end

    AST_GFX_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gfx_irq_hit, gfx_fiq_hit}) <= 1); // R5
    AST_GFX_MODE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        route[4] |-> (gfx_irq_hit == '0)); // R6
endmodule

// File: tb/irq_router_top_bench.sv
module irq_router_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_lvl_i = '0;
    logic [15:0] mbx_lvl_i = '0;
    logic        gfx_lvl_i = 1'b0;
    logic [3:0]  pmon_lvl_i = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  core_irq_o;
    logic [3:0]  core_fiq_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_router_top u_irq_router_top (.*);

    // {addr, wdata, tmr, mbx, gfx, pmon, exp_irq, exp_fiq}
    localparam int NV = 11;
    localparam logic [84:0] VEC [NV] = '{
        {8'h40, 32'h01, 16'h0001, 16'h0000, 1'b0, 4'h0, 4'b0001, 4'b0000}, // R2
        {8'h40, 32'h11, 16'h0001, 16'h0000, 1'b0, 4'h0, 4'b0000, 4'b0001}, // R3
        {8'hFC, 32'h00, 16'h0000, 16'h0000, 1'b0, 4'h0, 4'b0000, 4'b0000}, // R9
        {8'h4C, 32'h08, 16'h8001, 16'h0000, 1'b0, 4'h0, 4'b1000, 4'b0001}, // R2
        {8'h54, 32'h20, 16'h0000, 16'h0020, 1'b0, 4'h0, 4'b0000, 4'b0010}, // R4
        {8'h54, 32'h02, 16'h0000, 16'h0020, 1'b0, 4'h0, 4'b0010, 4'b0000}, // R4
        {8'h0C, 32'h02, 16'h0000, 16'h0000, 1'b1, 4'h0, 4'b0100, 4'b0000}, // R5
        {8'h0C, 32'h1E, 16'h0000, 16'h0000, 1'b1, 4'h0, 4'b0000, 4'b1000}, // R6
        {8'h10, 32'h05, 16'h0000, 16'h0000, 1'b0, 4'hF, 4'b0101, 4'b0000}, // R8
        {8'h14, 32'h01, 16'h0000, 16'h0000, 1'b0, 4'hF, 4'b0100, 4'b0000}, // R7
        {8'hFC, 32'hFFFFFFFF, 16'h0000, 16'h0000, 1'b0, 4'h0, 4'b0000, 4'b0000} // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 8'hFC; cfg_wdata = '0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {28'h0, core_irq_o}, 32'h0);
        chk("R1 fiq", {28'h0, core_fiq_o}, 32'h0);
        rd("R1 route", 8'h0C, 32'h0);
        rd("R1 pmon", 8'h10, 32'h0);
        rd("R1 tctl", 8'h40, 32'h0);
        rd("R1 mctl", 8'h5C, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][84:77], VEC[i][76:45]);
            tmr_lvl_i  = VEC[i][44:29];
            mbx_lvl_i  = VEC[i][28:13];
            gfx_lvl_i  = VEC[i][12];
            pmon_lvl_i = VEC[i][11:8];
            #1;
            chk($sformatf("R9 vec%0d irq", i), {28'h0, core_irq_o}, {28'h0, VEC[i][7:4]});
            chk($sformatf("R9 vec%0d fiq", i), {28'h0, core_fiq_o}, {28'h0, VEC[i][3:0]});
        end

        // Directed: state is tctl0=0x11, tctl3=0x08, mctl1=0x02, route=0x1E, pmon en=0100
        rd("R7 mask", 8'h10, 32'h4);
        rd("R10 unmapped", 8'hFC, 32'h0);
        rd("R10 route kept", 8'h0C, 32'h1E);
        wr(8'h14, 32'h0);
        rd("R7 zero clr", 8'h10, 32'h4);
        pmon_lvl_i = 4'hF;
        #1;
        rd("R8 ipend core2", 8'h68, 32'h200);
        rd("R8 fpend core2", 8'h78, 32'h0);
        pmon_lvl_i = 4'h0;
        tmr_lvl_i = 16'h0001;
        #1;
        rd("R3 fpend core0", 8'h70, 32'h1);
        rd("R3 ipend core0", 8'h60, 32'h0);
        tmr_lvl_i = 16'h0000;
        gfx_lvl_i = 1'b1;
        #1;
        rd("R6 fpend core3", 8'h7C, 32'h100);
        rd("R6 ipend core3", 8'h6C, 32'h0);
        mbx_lvl_i = 16'h0020;
        gfx_lvl_i = 1'b0;
        #1;
        rd("R4 ipend core1", 8'h64, 32'h20);
        wr(8'h0C, 32'h01);
        gfx_lvl_i = 1'b1;
        mbx_lvl_i = 16'h0;
        #1;
        rd("R5 ipend core1", 8'h64, 32'h100);
        rd("R5 ipend core0", 8'h60, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule